// File: doc/BRIEF.md
# Decode-Resolved Branch Front End

This block is the fetch and decode front end of an in-order five-stage pipeline. It owns the program counter and the register between fetch and decode, and it settles conditional branches at the end of decode. Because the branch outcome and its target are known one stage after fetch, a redirect affects at most the one instruction fetched alongside the branch decode.

A static two-bit policy input chooses how that one slot is handled. The block can hold fetch back until the outcome is known, keep fetching sequentially and discard the slot only on a taken branch, commit to the taken path and drop the slot for every branch, or always let the slot complete as a delay slot. The downstream stage supplies an advance enable. While it is low, the whole front end freezes, and any redirect or squash decision waits until it is high again.

The instruction memory is read combinationally at the presented address, gated by a read enable. The register file is read combinationally at the two source indices taken from the decode-stage instruction, and it returns the two operands that the branch compares.

Top module: `branch_front_end`

## Requirements
- R1: A synchronous reset (active-low `rst_n`) sets the program counter (`imem_addr_o`) to 0 and clears `id_valid_o`.
- R2: On an advancing cycle with no branch in decode, the decode register takes the instruction word at the current PC together with that PC, marked valid, and the PC grows by 4.
- R3: A decode-stage valid instruction is a branch when bits [31:26] equal 6'b000100 (taken if the operands are equal) or 6'b000101 (taken if they differ). The operand indices `rs_idx_o` = bits [25:21] and `rt_idx_o` = bits [20:16] of the decode instruction.
- R4: The branch target is the branch's own PC plus 4 plus the sign-extended bits [15:0] shifted left by two.
- R5: Policy 2'b00 (hold): with a branch in decode, `imem_rd_o` is low and the next decode slot is a bubble. The PC moves to the target if taken and otherwise stays at branch PC plus 4.
- R6: Policy 2'b01 (fall through): a not-taken branch costs nothing. A taken branch turns the next decode slot into a bubble and moves the PC to the target.
- R7: Policy 2'b10 (assume taken): every branch turns the next decode slot into a bubble. The PC goes to the target if taken and otherwise to branch PC plus 4.
- R8: Policy 2'b11 (delay slot): the instruction after a branch always enters decode valid. The PC goes to the target if taken and otherwise advances by 4.
- R9: While `adv_i` is low, the PC, `id_valid_o`, `id_instr_o` and `id_pc_o` hold, `imem_rd_o` is low, and a branch in decode is acted on only in the first cycle with `adv_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Hazard policy, static outside reset |
| adv_i | input | 1 | Downstream advance enable |
| imem_rd_o | output | 1 | Instruction memory read enable |
| imem_addr_o | output | PCW | Program counter / fetch address |
| imem_data_i | input | 32 | Instruction word at `imem_addr_o` |
| rs_idx_o | output | 5 | First operand register index |
| rt_idx_o | output | 5 | Second operand register index |
| rs_data_i | input | XLEN | First operand value |
| rt_data_i | input | XLEN | Second operand value |
| id_valid_o | output | 1 | Decode slot holds a live instruction |
| id_instr_o | output | 32 | Decode-stage instruction |
| id_pc_o | output | PCW | Decode-stage instruction address |

## Verification
Every registered result (PC, decode slot valid, instruction and address) is due one clock edge after the advancing cycle that causes it. The read enable is combinational and is due in the same cycle as the enable and the decode contents. The bench drives `adv_i` at the falling edge and samples the read enable one time step later in that same low phase. It then advances its own model by one edge and compares the registered outputs at the next falling edge, so each comparison sees exactly the edge it predicts. Directed branches at address 0 add fixed expected addresses for each policy on top of the model.

// File: rtl/fe_pkg.sv
// Package: shared encodings for the decode-resolved branch front end.
// Assumes 32-bit instruction words with a 6-bit major opcode at the top.
package fe_pkg;

    localparam int ILEN     = 32;
    localparam int OPW      = 6;
    localparam int REGIDX_W = 5;
    localparam int IMM_W    = 16;

    // Field positions that the decode logic relies on.
    localparam int OP_LSB = 26;
    localparam int RS_LSB = 21;
    localparam int RT_LSB = 16;

    localparam logic [OPW-1:0] OP_BR_EQ = 6'b000100;
    localparam logic [OPW-1:0] OP_BR_NE = 6'b000101;

    typedef enum logic [1:0] {
        POL_HOLD      = 2'b00,
        POL_FALLTHRU  = 2'b01,
        POL_ASSUME_TK = 2'b10,
        POL_DELAYSLOT = 2'b11
    } policy_e;

endpackage

// File: rtl/fe_pc_reg.sv
// Module: program counter register with its next-address selection.
// Assumes redirect and hold are mutually exclusive and only meaningful
// when load_i is high; a frozen cycle keeps the current value.
module fe_pc_reg #(
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           redirect_i,
    input  logic           hold_i,
    input  logic [PCW-1:0] target_i,
    output logic [PCW-1:0] pc_o
);

    localparam logic [PCW-1:0] STEP = PCW'(4);

    logic [PCW-1:0] pc_q;
    logic [PCW-1:0] pc_next;

    // Choose the next fetch address from redirect, hold or sequential step.
    always_comb begin
        pc_next = pc_q;
        if (load_i) begin
            if (redirect_i) begin
                pc_next = target_i;
            end else if (!hold_i) begin
                pc_next = pc_q + STEP;
            end
        end
    end

    // Register the program counter with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

    // R1
    pc_reset_chk: assert property (@(posedge clk) !rst_n |=> (pc_q == '0));

    // R9
    pc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(pc_q));

endmodule

// File: rtl/fe_ifid_reg.sv
// Module: the register between fetch and decode.
// Assumes squash_i is only acted on in a cycle where load_i is high; a
// squashed load still captures the word but marks the slot not valid.
module fe_ifid_reg #(
    parameter int PCW  = 32,
    parameter int ILEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            squash_i,
    input  logic [ILEN-1:0] instr_i,
    input  logic [PCW-1:0]  pc_i,
    output logic            vld_o,
    output logic [ILEN-1:0] instr_o,
    output logic [PCW-1:0]  pc_o
);

    logic            vld_q;
    logic [ILEN-1:0] instr_q;
    logic [PCW-1:0]  pc_q;

    // Valid bit: cleared by reset, rewritten on every advancing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (load_i) begin
            vld_q <= !squash_i;
        end
    end

    // Payload: instruction word and its address, captured when advancing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            pc_q    <= '0;
        end else if (load_i) begin
            instr_q <= instr_i;
            pc_q    <= pc_i;
        end
    end

    assign vld_o   = vld_q;
    assign instr_o = instr_q;
    assign pc_o    = pc_q;

    // R1
    ifid_reset_chk: assert property (@(posedge clk) !rst_n |=> !vld_q);

    // R9
    ifid_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(vld_q) && $stable(instr_q) && $stable(pc_q)));

endmodule

// File: rtl/fe_branch_unit.sv
// Module: decode-stage branch detection, operand compare and target adder.
// Assumes register operands arrive combinationally for the indices it
// drives out in the same cycle.
module fe_branch_unit
    import fe_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PCW  = 32
) (
    input  logic                vld_i,
    input  logic [ILEN-1:0]     instr_i,
    input  logic [PCW-1:0]      pc_i,
    input  logic [XLEN-1:0]     rs_val_i,
    input  logic [XLEN-1:0]     rt_val_i,
    output logic [REGIDX_W-1:0] rs_idx_o,
    output logic [REGIDX_W-1:0] rt_idx_o,
    output logic                is_br_o,
    output logic                taken_o,
    output logic [PCW-1:0]      target_o
);

    localparam int EXT_W = PCW - IMM_W - 2;

    logic [OPW-1:0]   opcode;
    logic [IMM_W-1:0] imm;
    logic             ops_equal;
    logic [PCW-1:0]   seq_pc;
    logic [PCW-1:0]   byte_offs;

    // Split the decode instruction into its fields.
    always_comb begin
        opcode   = instr_i[OP_LSB +: OPW];
        rs_idx_o = instr_i[RS_LSB +: REGIDX_W];
        rt_idx_o = instr_i[RT_LSB +: REGIDX_W];
        imm      = instr_i[IMM_W-1:0];
    end

    // Recognise a branch and resolve its direction from the operands.
    always_comb begin
        ops_equal = (rs_val_i == rt_val_i);
        is_br_o   = vld_i && ((opcode == OP_BR_EQ) || (opcode == OP_BR_NE));
        taken_o   = 1'b0;
        if (is_br_o) begin
            taken_o = (opcode == OP_BR_EQ) ? ops_equal : !ops_equal;
        end
    end

    // Form the target from the following address and the scaled offset.
    always_comb begin
        seq_pc    = pc_i + PCW'(4);
        byte_offs = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        target_o  = seq_pc + byte_offs;
    end

endmodule

// File: rtl/fe_hazard_ctl.sv
// Module: turns the selected policy and the branch outcome into squash,
// redirect, hold and fetch-enable controls.
// Assumes mode_i is static outside reset; all outputs are combinational.
module fe_hazard_ctl
    import fe_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       adv_i,
    input  logic       is_br_i,
    input  logic       taken_i,
    output logic       squash_o,
    output logic       redirect_o,
    output logic       hold_o,
    output logic       rd_en_o
);

    policy_e pol;

    // Decode the policy code into the enumerated type.
    always_comb begin
        pol = policy_e'(mode_i);
    end

    // Per-policy control of the fetch slot and the program counter.
    always_comb begin
        redirect_o = taken_i;
        squash_o   = 1'b0;
        hold_o     = 1'b0;
        rd_en_o    = adv_i;
        unique case (pol)
            POL_HOLD: begin
                squash_o = is_br_i;
                hold_o   = is_br_i && !taken_i;
                rd_en_o  = adv_i && !is_br_i;
            end
            POL_FALLTHRU: begin
                squash_o = taken_i;
            end
            POL_ASSUME_TK: begin
                squash_o = is_br_i;
                hold_o   = is_br_i && !taken_i;
            end
            POL_DELAYSLOT: begin
                squash_o = 1'b0;
            end
            default: begin
                squash_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/branch_front_end.sv
// Module: top of the decode-resolved branch front end.
// Holds the PC and the fetch/decode register, resolves branches in decode
// and applies one of four slot policies. Assumes combinational instruction
// memory and register-file reads, and PCW of at least 18.
module branch_front_end
    import fe_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PCW  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                adv_i,
    output logic                imem_rd_o,
    output logic [PCW-1:0]      imem_addr_o,
    input  logic [ILEN-1:0]     imem_data_i,
    output logic [REGIDX_W-1:0] rs_idx_o,
    output logic [REGIDX_W-1:0] rt_idx_o,
    input  logic [XLEN-1:0]     rs_data_i,
    input  logic [XLEN-1:0]     rt_data_i,
    output logic                id_valid_o,
    output logic [ILEN-1:0]     id_instr_o,
    output logic [PCW-1:0]      id_pc_o
);

    logic           pc_redirect;
    logic           pc_hold;
    logic           slot_squash;
    logic           fetch_en;
    logic           br_in_id;
    logic           br_taken;
    logic [PCW-1:0] br_target;
    logic [PCW-1:0] pc_cur;
    logic           id_vld;
    logic [ILEN-1:0] id_instr;
    logic [PCW-1:0] id_pc;

    fe_pc_reg #(.PCW(PCW)) pc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (adv_i),
        .redirect_i (pc_redirect),
        .hold_i     (pc_hold),
        .target_i   (br_target),
        .pc_o       (pc_cur)
    );

    fe_ifid_reg #(.PCW(PCW), .ILEN(ILEN)) ifid_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (adv_i),
        .squash_i (slot_squash),
        .instr_i  (imem_data_i),
        .pc_i     (pc_cur),
        .vld_o    (id_vld),
        .instr_o  (id_instr),
        .pc_o     (id_pc)
    );

    fe_branch_unit #(.XLEN(XLEN), .PCW(PCW)) bru_i (
        .vld_i    (id_vld),
        .instr_i  (id_instr),
        .pc_i     (id_pc),
        .rs_val_i (rs_data_i),
        .rt_val_i (rt_data_i),
        .rs_idx_o (rs_idx_o),
        .rt_idx_o (rt_idx_o),
        .is_br_o  (br_in_id),
        .taken_o  (br_taken),
        .target_o (br_target)
    );

    fe_hazard_ctl hz_i (
        .mode_i     (mode_i),
        .adv_i      (adv_i),
        .is_br_i    (br_in_id),
        .taken_i    (br_taken),
        .squash_o   (slot_squash),
        .redirect_o (pc_redirect),
        .hold_o     (pc_hold),
        .rd_en_o    (fetch_en)
    );

    // Drive the memory-side and downstream-side ports.
    always_comb begin
        imem_rd_o   = fetch_en;
        imem_addr_o = pc_cur;
        id_valid_o  = id_vld;
        id_instr_o  = id_instr;
        id_pc_o     = id_pc;
    end

    // R2
    seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !br_in_id) |=>
        (id_valid_o && (id_pc_o == $past(imem_addr_o)) &&
         (imem_addr_o == $past(imem_addr_o) + PCW'(4))));

    // R5
    hold_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == POL_HOLD) && br_in_id) |-> !imem_rd_o);

    // R6
    fallthru_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == POL_FALLTHRU) && adv_i && br_taken) |=>
        (!id_valid_o && (imem_addr_o == $past(br_target))));

    // R7
    assume_tk_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == POL_ASSUME_TK) && adv_i && br_in_id) |=> !id_valid_o);

    // R8
    delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == POL_DELAYSLOT) && adv_i && br_in_id) |=> id_valid_o);

    // R9
    frozen_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |-> !imem_rd_o);

endmodule

// File: tb/branch_front_end_tb_top.sv
`timescale 1ns/1ps
module branch_front_end_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        adv_i;
    logic        imem_rd_o;
    logic [31:0] imem_addr_o;
    logic [31:0] imem_data_i;
    logic [4:0]  rs_idx_o, rt_idx_o;
    logic [31:0] rs_data_i, rt_data_i;
    logic        id_valid_o;
    logic [31:0] id_instr_o;
    logic [31:0] id_pc_o;

    logic [31:0] prog [64];
    logic [31:0] regs [32];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [31:0] m_pc, m_instr, m_idpc;
    logic        m_v;
    logic [1:0]  m_mode;
    string       m_tag;

    always #10 clk = ~clk;

    assign imem_data_i = prog[imem_addr_o[7:2]];
    assign rs_data_i   = regs[rs_idx_o];
    assign rt_data_i   = regs[rt_idx_o];

    branch_front_end #(.XLEN(32), .PCW(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .adv_i(adv_i),
        .imem_rd_o(imem_rd_o), .imem_addr_o(imem_addr_o),
        .imem_data_i(imem_data_i), .rs_idx_o(rs_idx_o), .rt_idx_o(rt_idx_o),
        .rs_data_i(rs_data_i), .rt_data_i(rt_data_i),
        .id_valid_o(id_valid_o), .id_instr_o(id_instr_o), .id_pc_o(id_pc_o)
    );

    function automatic logic [31:0] mk_br(bit ne, int rs, int rt, int off);
        logic [31:0] o = off;
        logic [31:0] s = rs;
        logic [31:0] t = rt;
        return {5'b00010, ne, s[4:0], t[4:0], o[15:0]};
    endfunction

    function automatic logic [31:0] mk_alu();
        logic [31:0] w = $urandom;
        return {6'b100011, w[25:0]};
    endfunction

    function automatic logic [31:0] tgt_of(logic [31:0] pc, logic [31:0] ins);
        return pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 64; i++) begin
            if (($urandom % 10) < 4)
                prog[i] = mk_br($urandom % 2, $urandom % 4, $urandom % 4,
                                int'($urandom % 9) - 4);
            else
                prog[i] = mk_alu();
        end
        for (int i = 0; i < 32; i++) regs[i] = $urandom % 2;
    endtask

    task automatic do_reset(logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0; mode_i = mode; adv_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pc after reset", imem_addr_o, 32'd0);
        check("R1 valid after reset", {31'd0, id_valid_o}, 32'd0);
        rst_n = 1'b1;
        m_pc = 0; m_v = 0; m_instr = 0; m_idpc = 0; m_mode = mode;
    endtask

    // One cycle: drive adv, check read enable, step model, compare state.
    task automatic one_cycle(bit adv);
        logic [5:0]  op;
        logic        br, tk, nv, exp_rd;
        logic [31:0] tg, npc, ni, nip;
        adv_i = adv;
        #1;
        op = m_instr[31:26];
        br = m_v && (op == 6'h04 || op == 6'h05);
        tk = br && ((op == 6'h04) ? (regs[m_instr[25:21]] == regs[m_instr[20:16]])
                                  : (regs[m_instr[25:21]] != regs[m_instr[20:16]]));
        tg = tgt_of(m_idpc, m_instr);
        exp_rd = adv && !(m_mode == 2'b00 && br);
        check(!adv ? "R9 read enable frozen" :
              (br && m_mode == 2'b00) ? "R5 read enable on branch" : "R2 read enable",
              {31'd0, imem_rd_o}, {31'd0, exp_rd});
        if (adv) begin
            nv = 1'b1; ni = prog[m_pc[7:2]]; nip = m_pc; npc = m_pc + 32'd4;
            m_tag = "R2 sequential";
            case (m_mode)
                2'b00: if (br) begin nv = 0; npc = tk ? tg : m_pc; m_tag = "R5 R3 R4 hold"; end
                2'b01: begin
                    if (tk) begin nv = 0; npc = tg; end
                    if (br) m_tag = "R6 R3 R4 fallthru";
                end
                2'b10: if (br) begin nv = 0; npc = tk ? tg : m_pc; m_tag = "R7 R3 R4 assume taken"; end
                default: begin
                    if (tk) npc = tg;
                    if (br) m_tag = "R8 R3 R4 delay slot";
                end
            endcase
            m_v = nv; m_instr = ni; m_idpc = nip; m_pc = npc;
        end else begin
            m_tag = "R9 frozen";
        end
        @(negedge clk);
        check(m_tag, imem_addr_o, m_pc);
        check(m_tag, {31'd0, id_valid_o}, {31'd0, m_v});
        if (m_v) begin
            check(m_tag, id_instr_o, m_instr);
            check(m_tag, id_pc_o, m_idpc);
            check("R3 operand index", {22'd0, rs_idx_o, rt_idx_o},
                  {22'd0, m_instr[25:21], m_instr[20:16]});
        end
    endtask

    task automatic directed(logic [1:0] mode, bit ne, bit exp_v,
                            logic [31:0] exp_addr, string tag);
        for (int i = 0; i < 64; i++) prog[i] = {6'b100011, 26'(i)};
        prog[0] = mk_br(ne, 1, 1, 3);
        regs[1] = 32'h5;
        do_reset(mode);
        one_cycle(1'b1);
        one_cycle(1'b0);
        one_cycle(1'b1);
        check({tag, " directed addr"}, imem_addr_o, exp_addr);
        check({tag, " directed valid"}, {31'd0, id_valid_o}, {31'd0, exp_v});
    endtask

    initial begin
        rst_n = 1'b0; mode_i = 2'b00; adv_i = 1'b0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) prog[i] = 32'd0;
        for (int i = 0; i < 32; i++) regs[i] = 32'd0;

        // taken branch at 0 to 16; not-taken variant
        directed(2'b00, 1'b0, 1'b0, 32'd16, "R5 R4 taken");
        directed(2'b00, 1'b1, 1'b0, 32'd4,  "R5 not taken");
        directed(2'b01, 1'b0, 1'b0, 32'd16, "R6 R4 taken");
        directed(2'b01, 1'b1, 1'b1, 32'd8,  "R6 not taken");
        directed(2'b10, 1'b0, 1'b0, 32'd16, "R7 R4 taken");
        directed(2'b10, 1'b1, 1'b0, 32'd4,  "R7 not taken");
        directed(2'b11, 1'b0, 1'b1, 32'd16, "R8 R4 taken");
        directed(2'b11, 1'b1, 1'b1, 32'd8,  "R8 not taken");

        for (int m = 0; m < 4; m++) begin
            fill_random();
            do_reset(2'(m));
            for (int c = 0; c < 1500; c++) begin
                one_cycle(($urandom % 100) < 80);
                if ((c % 300) == 299) for (int i = 0; i < 4; i++) regs[i] = $urandom % 2;
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule